// File: doc/BRIEF.md
# Shared-Pin Parallel I/O Port

This block is a six-pin parallel I/O port with a byte-wide register bus. A direction register and a data register set what each pin does when software owns it. Each pin also has two alternative owners. The first is an alternate digital function that brings its own output enable and output value. The second is an analog function that needs the pad left alone. A fixed per-pin priority picks the owner: analog first, then alternate digital, then plain GPIO. The block drives the pad output-enable and output-value lines from that choice, gates the pad input buffer, and builds the value returned by a read of the data register.

Reads follow the direction bit even when another function owns the pad. An output pin reads back its latched data bit. An input pin reads the pad level after a two-flop synchroniser, or 0 when its input buffer is switched off. A low-power hold input freezes the pad controls and the read data, and blocks register writes, so the pins keep their state through sleep.

Top module: `pinmux_port`

## Requirements
- R1: After reset the data and direction registers are zero. `pad_oe` and `pad_out` are all 0, `pad_ie` is all 1, and reads of either register return 0 while the pads are low.
- R2: Register address 0 selects the data register and address 1 selects the direction register. Bits 7 and 6 of every read return 0, and written values in those bits are dropped.
- R3: A pin whose `alt_en` and `ana_en` are both 0 has `pad_oe` equal to its direction bit (1 = output) and `pad_out` equal to its data bit. `pad_oe`, `pad_out` and `pad_ie` are registered and follow their sources one clock later.
- R4: A pin with `alt_en` = 1 and `ana_en` = 0 takes `pad_oe` from `alt_oe` and `pad_out` from `alt_out`.
- R5: A pin with `ana_en` = 1 has `pad_oe` = 0, `pad_out` = 0 and `pad_ie` = 0, whatever its `alt_en` is. Any pin with `ana_en` = 0 has `pad_ie` = 1.
- R6: A data-register read returns the latched data bit for every pin whose direction bit is 1, whoever owns that pin.
- R7: For a pin whose direction bit is 0, a data read returns `pad_in` after two synchroniser flops, or 0 if `ana_en` is 1. `bus_rdata` is loaded on the clock edge where `bus_rd` is high, so a pad change is seen by a read that samples on the third edge after the change.
- R8: A data write to a pin whose direction is input is still stored. When that pin is later made an output, it drives the stored value.
- R9: While `lp_hold` is 1, `pad_oe`, `pad_out`, `pad_ie` and `bus_rdata` keep their values and register writes are ignored. After `lp_hold` falls, the earlier register contents are still in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 1 | Register select: 0 data, 1 direction |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, loads bus_rdata |
| bus_rdata | output | 8 | Registered read data |
| lp_hold | input | 1 | Low-power hold: freeze outputs, block writes |
| alt_en | input | 6 | Per-pin alternate digital function enable |
| alt_oe | input | 6 | Alternate function output enable |
| alt_out | input | 6 | Alternate function output value |
| ana_en | input | 6 | Per-pin analog function enable |
| pad_in | input | 6 | Pad input level (asynchronous) |
| pad_oe | output | 6 | Pad output buffer enable |
| pad_out | output | 6 | Pad output value |
| pad_ie | output | 6 | Pad input buffer enable |

## Verification
The hardest cases to reach are pins whose owner and direction disagree. One example is an input-direction pin held by the analog function, which must read 0 even though its pad is high. Another is an output-direction pin handed to the alternate function, which must still read back its data bit. The vector table sets different per-pin mixes of direction, alternate and analog enables in one pattern, so each vector covers several ownership cases at once. A directed step then changes `pad_in` while issuing back-to-back reads, to show the two-edge synchroniser delay. Another step writes registers and toggles analog enables while the hold is set, and confirms at the pads that nothing moved.

// File: rtl/pinmux_port_pkg.sv
package pinmux_port_pkg;
    parameter int PORT_PINS = 6;
    parameter int PORT_BUS_W = 8;
    parameter int SYNC_STAGES = 2;

    typedef enum logic {
        REG_DATA = 1'b0,
        REG_DIR  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
    import pinmux_port_pkg::*;
#(
    parameter int PINS  = PORT_PINS,
    parameter int BUS_W = PORT_BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             addr,
    input  logic [BUS_W-1:0] wdata,
    input  logic             hold,
    output logic [PINS-1:0]  data_q,
    output logic [PINS-1:0]  dir_q
);
    typedef struct packed {
        logic [PINS-1:0] data;
        logic [PINS-1:0] dir;
    } regs_t;

    regs_t r_d, r_q;
    reg_sel_e sel;

    always_comb begin
        sel = reg_sel_e'(addr);
        r_d = r_q;
        if (wr && !hold) begin
            if (sel == REG_DATA) r_d.data = wdata[PINS-1:0];
            else                 r_d.dir  = wdata[PINS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign data_q = r_q.data;
    assign dir_q  = r_q.dir;
endmodule

// File: rtl/pinmux_sync.sv
module pinmux_sync
    import pinmux_port_pkg::*;
#(
    parameter int PINS   = PORT_PINS,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] async_in,
    output logic [PINS-1:0] sync_out
);
    logic [PINS-1:0] stage_d [STAGES];
    logic [PINS-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_comb stage_d[s] = async_in;
        end else begin : g_next
            always_comb stage_d[s] = stage_q[s-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_d[s];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/pinmux_own.sv
module pinmux_own
    import pinmux_port_pkg::*;
#(
    parameter int PINS = PORT_PINS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic [PINS-1:0] gpio_dir,
    input  logic [PINS-1:0] gpio_data,
    input  logic [PINS-1:0] alt_en,
    input  logic [PINS-1:0] alt_oe,
    input  logic [PINS-1:0] alt_out,
    input  logic [PINS-1:0] ana_en,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_ie
);
    typedef struct packed {
        logic [PINS-1:0] oe;
        logic [PINS-1:0] out;
        logic [PINS-1:0] ie;
    } padc_t;

    padc_t pc_d, pc_q;
    logic [PINS-1:0] own_oe, own_out, own_ie;

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        always_comb begin
            if (ana_en[i]) begin
                own_oe[i]  = 1'b0;
                own_out[i] = 1'b0;
                own_ie[i]  = 1'b0;
            end else if (alt_en[i]) begin
                own_oe[i]  = alt_oe[i];
                own_out[i] = alt_out[i];
                own_ie[i]  = 1'b1;
            end else begin
                own_oe[i]  = gpio_dir[i];
                own_out[i] = gpio_data[i];
                own_ie[i]  = 1'b1;
            end
        end
    end

    always_comb begin
        pc_d = pc_q;
        if (!hold) begin
            pc_d.oe  = own_oe;
            pc_d.out = own_out;
            pc_d.ie  = own_ie;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q.oe  <= '0;
            pc_q.out <= '0;
            pc_q.ie  <= '1;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign pad_oe  = pc_q.oe;
    assign pad_out = pc_q.out;
    assign pad_ie  = pc_q.ie;
endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
    import pinmux_port_pkg::*;
#(
    parameter int PINS  = PORT_PINS,
    parameter int BUS_W = PORT_BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic             bus_wr,
    input  logic             bus_rd,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             lp_hold,
    input  logic [PINS-1:0]  alt_en,
    input  logic [PINS-1:0]  alt_oe,
    input  logic [PINS-1:0]  alt_out,
    input  logic [PINS-1:0]  ana_en,
    input  logic [PINS-1:0]  pad_in,
    output logic [PINS-1:0]  pad_oe,
    output logic [PINS-1:0]  pad_out,
    output logic [PINS-1:0]  pad_ie
);
    logic [PINS-1:0]  data_q, dir_q, pin_sync, data_view;
    logic [BUS_W-1:0] rdata_d, rdata_q;

    pinmux_regs #(.PINS(PINS), .BUS_W(BUS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .hold(lp_hold), .data_q(data_q), .dir_q(dir_q)
    );

    pinmux_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pin_sync)
    );

    pinmux_own #(.PINS(PINS)) u_own (
        .clk(clk), .rst_n(rst_n), .hold(lp_hold),
        .gpio_dir(dir_q), .gpio_data(data_q),
        .alt_en(alt_en), .alt_oe(alt_oe), .alt_out(alt_out), .ana_en(ana_en),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_ie(pad_ie)
    );

    // Direction picks the read source; a gated input buffer reads as 0.
    for (genvar i = 0; i < PINS; i++) begin : g_view
        always_comb begin
            if (dir_q[i])       data_view[i] = data_q[i];
            else if (ana_en[i]) data_view[i] = 1'b0;
            else                data_view[i] = pin_sync[i];
        end
    end

    always_comb begin
        rdata_d = rdata_q;
        if (bus_rd && !lp_hold) begin
            rdata_d = '0;
            if (reg_sel_e'(bus_addr) == REG_DATA) rdata_d[PINS-1:0] = data_view;
            else                                  rdata_d[PINS-1:0] = dir_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/pinmux_port_chk.sv
module pinmux_port_chk #(
    parameter int PINS  = 6,
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lp_hold,
    input logic [PINS-1:0]  alt_en,
    input logic [PINS-1:0]  alt_oe,
    input logic [PINS-1:0]  alt_out,
    input logic [PINS-1:0]  ana_en,
    input logic [PINS-1:0]  pad_oe,
    input logic [PINS-1:0]  pad_out,
    input logic [PINS-1:0]  pad_ie,
    input logic [BUS_W-1:0] bus_rdata,
    input logic [PINS-1:0]  data_q,
    input logic [PINS-1:0]  dir_q
);
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1:PINS] == '0);

    assert_gpio_own_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lp_hold |=> ((((pad_oe ^ $past(dir_q)) | (pad_out ^ $past(data_q)))
                       & $past(~alt_en & ~ana_en)) == '0));

    assert_alt_own_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lp_hold |=> ((((pad_oe ^ $past(alt_oe)) | (pad_out ^ $past(alt_out)))
                       & $past(alt_en & ~ana_en)) == '0));

    assert_analog_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !lp_hold |=> (((pad_oe | pad_out) & $past(ana_en)) == '0)
                     && (pad_ie == $past(~ana_en)));

    assert_hold_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lp_hold |=> $stable(pad_oe) && $stable(pad_out) && $stable(pad_ie)
                    && $stable(bus_rdata) && $stable(data_q) && $stable(dir_q));
endmodule

bind pinmux_port pinmux_port_chk #(.PINS(PINS), .BUS_W(BUS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lp_hold(lp_hold),
    .alt_en(alt_en), .alt_oe(alt_oe), .alt_out(alt_out), .ana_en(ana_en),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_ie(pad_ie),
    .bus_rdata(bus_rdata), .data_q(data_q), .dir_q(dir_q)
);

// File: tb/pinmux_port_bench.sv
`timescale 1ns/1ps
module pinmux_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       lp_hold = 1'b0;
    logic [5:0] alt_en = '0, alt_oe = '0, alt_out = '0, ana_en = '0, pad_in = '0;
    logic [5:0] pad_oe, pad_out, pad_ie;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pinmux_port u_pinmux_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .lp_hold(lp_hold),
        .alt_en(alt_en), .alt_oe(alt_oe), .alt_out(alt_out), .ana_en(ana_en),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_ie(pad_ie)
    );

    // dir, data, alt_en, alt_oe, alt_out, ana_en, pad_in | oe, out, ie, rd
    localparam logic [10:0][5:0] VEC [6] = '{
        '{6'h3F, 6'h2A, 6'h00, 6'h00, 6'h00, 6'h00, 6'h15, 6'h3F, 6'h2A, 6'h3F, 6'h2A},
        '{6'h00, 6'h2A, 6'h00, 6'h00, 6'h00, 6'h00, 6'h15, 6'h00, 6'h2A, 6'h3F, 6'h15},
        '{6'h0F, 6'h33, 6'h30, 6'h10, 6'h20, 6'h00, 6'h3C, 6'h1F, 6'h23, 6'h3F, 6'h33},
        '{6'h3F, 6'h3F, 6'h00, 6'h00, 6'h00, 6'h0F, 6'h00, 6'h30, 6'h30, 6'h30, 6'h3F},
        '{6'h00, 6'h00, 6'h0C, 6'h0C, 6'h0C, 6'h06, 6'h3F, 6'h08, 6'h08, 6'h39, 6'h39},
        '{6'h2A, 6'h15, 6'h3F, 6'h00, 6'h3F, 6'h00, 6'h2A, 6'h00, 6'h3F, 6'h3F, 6'h00}
    };

    task automatic check(input string req, input string what, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pads(input string req, input logic [5:0] oe, input logic [5:0] o,
                        input logic [5:0] ie);
        check(req, "pad_oe", {2'b0, pad_oe}, {2'b0, oe});
        check(req, "pad_out", {2'b0, pad_out}, {2'b0, o});
        check(req, "pad_ie", {2'b0, pad_ie}, {2'b0, ie});
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        pads("R1", 6'h00, 6'h00, 6'h3F);
        bus_read(1'b0); check("R1", "data read", bus_rdata, 8'h00);
        bus_read(1'b1); check("R1", "dir read", bus_rdata, 8'h00);

        // Vector table: R3 R4 R5 R6 R7
        for (int v = 0; v < 6; v++) begin
            bus_write(1'b0, {2'b0, VEC[v][9]});
            bus_write(1'b1, {2'b0, VEC[v][10]});
            @(negedge clk);
            alt_en = VEC[v][8]; alt_oe = VEC[v][7]; alt_out = VEC[v][6];
            ana_en = VEC[v][5]; pad_in = VEC[v][4];
            settle();
            pads("R3/R4/R5", VEC[v][3], VEC[v][2], VEC[v][1]);
            bus_read(1'b0);
            check("R6/R7", "data read", bus_rdata, {2'b0, VEC[v][0]});
        end

        alt_en = '0; alt_oe = '0; alt_out = '0; ana_en = '0; pad_in = '0;

        // R2 upper bits
        bus_write(1'b1, 8'hFF);
        bus_write(1'b0, 8'hFF);
        bus_read(1'b1); check("R2", "dir read", bus_rdata, 8'h3F);
        bus_read(1'b0); check("R2", "data read", bus_rdata, 8'h3F);

        // R8 write while input, then switch to output
        bus_write(1'b1, 8'h00);
        bus_write(1'b0, 8'h2D);
        settle();
        check("R8", "pad_oe while input", {2'b0, pad_oe}, 8'h00);
        bus_read(1'b0); check("R8", "input read", bus_rdata, 8'h00);
        bus_write(1'b1, 8'h3F);
        settle();
        pads("R8", 6'h3F, 6'h2D, 6'h3F);
        bus_read(1'b0); check("R8", "output read", bus_rdata, 8'h2D);

        // R9 hold freezes pads and read data, blocks writes
        @(negedge clk); lp_hold = 1'b1;
        settle();
        bus_write(1'b0, 8'h00);
        bus_write(1'b1, 8'h00);
        @(negedge clk); ana_en = 6'h3F;
        settle();
        pads("R9", 6'h3F, 6'h2D, 6'h3F);
        bus_read(1'b1); check("R9", "rdata frozen", bus_rdata, 8'h2D);
        @(negedge clk); lp_hold = 1'b0; ana_en = '0;
        settle();
        bus_read(1'b0); check("R9", "data kept", bus_rdata, 8'h2D);
        bus_read(1'b1); check("R9", "dir kept", bus_rdata, 8'h3F);

        // R7 two-flop synchroniser latency on an input pin
        bus_write(1'b1, 8'h00);
        settle();
        @(negedge clk);
        pad_in = 6'h3F; bus_addr = 1'b0; bus_rd = 1'b1;
        @(negedge clk); check("R7", "edge 1", bus_rdata, 8'h00);
        @(negedge clk); check("R7", "edge 2", bus_rdata, 8'h00);
        @(negedge clk); check("R7", "edge 3", bus_rdata, 8'h3F);
        bus_rd = 1'b0;

        // R1 reset in mid-run
        bus_write(1'b1, 8'h3F);
        settle();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; pad_in = '0;
        @(negedge clk);
        pads("R1", 6'h00, 6'h00, 6'h3F);
        bus_read(1'b1); check("R1", "dir after reset", bus_rdata, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule